// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal valid/ready request port and an external asynchronous static RAM of 262,144 sixteen-bit words that has a separate enable for each byte lane. Each accepted request becomes one complete read or write cycle on the RAM pins. The pins are the address, chip select, write strobe, output-enable strobe and two byte-lane enables, all active low. The block also drives the output-enable of the tri-state data bus. Reads return their data through a response port that carries a one-cycle valid pulse.

The length of each phase comes from cycle counts that the block works out at elaboration from the clock period and the RAM's nanosecond minimums. At the default 20 ns clock, a read holds the RAM selected for three cycles and the write strobe is low for three cycles. The output-enable strobe stays high for the whole of every write. The controller turns its data drivers on only after the write strobe is low, and turns them off one cycle after the strobe rises. When a write follows a read, the controller first spends an idle turnaround phase so that the RAM can release the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output-enable strobe and both lane enables are high, the data drivers are off, req_ready is high and rsp_valid is low.
- R2: A read holds chip select and the output-enable strobe low with the write strobe high for at least 3 cycles (ceil(55 ns / 20 ns)). The data is then returned on rsp_rdata while rsp_valid is high for exactly one cycle.
- R3: On a read, req_be bit 0 selects bits 7:0 and req_be bit 1 selects bits 15:8. The lane enable of an unselected lane stays high, and the returned byte for that lane is zero.
- R4: On a write, only the lanes selected by req_be (bit 0 for bits 7:0, bit 1 for bits 15:8) change in the RAM. With req_be = 2'b00 no data changes.
- R5: During a write the write strobe is low for at least 3 cycles, and the output-enable strobe stays high for as long as the write strobe is low.
- R6: The data drivers are on only while chip select and the output-enable strobe are low and high respectively. They turn on after the write strobe falls, drive for at least 2 cycles before it rises, and stay on for one cycle after it rises.
- R7: mem_addr does not change in any cycle that follows a cycle in which chip select and the write strobe were both low.
- R8: When a write is accepted in the cycle right after a read completes, at least 4 full cycles pass between the output-enable strobe rising and the data drivers turning on.
- R9: req_ready is low while a RAM cycle is in progress, and a request is taken only when req_ready is high.
- R10: All 18 address bits reach mem_addr unchanged for the whole access, including address 18'h3FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte-lane select, active high |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output-enable strobe, active low |
| mem_lane_n | output | 2 | RAM lane enables, active low; bit 0 lower, bit 1 upper |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Output-enable of the tri-state data drivers |
| mem_dq_in | input | 16 | Data bus as seen from the RAM |

## Verification
The RAM model in the bench returns a filler byte on every lane whose enable is high. A read path that ignored the lane mask would therefore return that filler instead of zero. Partial and empty writes to one word, read back in full, expose a write that touches the wrong lane. A write issued in the cycle right after a read shows whether the turnaround phase was skipped, because the drivers would then come on one cycle early. Per-cycle monitors catch short strobes, a missing data setup window, drivers left on while the output-enable strobe is low, and the address moving inside the write overlap.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSET,
    PH_WPULSE,
    PH_WREC
  } phase_e;

  function automatic int ns_to_cyc(input int ns_val, input int per_ns);
    int c;
    c = (ns_val + per_ns - 1) / per_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DW = 16,
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic [DW-1:0]    dq_in,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  logic [DW-1:0] masked;
  logic [DW-1:0] data_q;
  logic          vld_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = lane_sel[g] ? dq_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= cap_en;
      if (cap_en) data_q <= masked;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int CW            = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 30,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_BUSOFF_NS   = 20,
  localparam int LANES        = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LANES-1:0] req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [LANES-1:0] mem_lane_n,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  input  logic [DW-1:0]    mem_dq_in
);
  // Read: selected for the longest of cycle, address and strobe access.
  localparam int RD_CYC = imax(imax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                               ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
  // Write strobe: pulse width, address-valid window less the set-up cycle,
  // and data set-up plus the one cycle before the drivers turn on.
  localparam int WP_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                    ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - 1),
                               ns_to_cyc(T_DW_NS, CLK_PERIOD_NS) + 1);
  localparam int TA_CYC = ns_to_cyc(T_BUSOFF_NS, CLK_PERIOD_NS);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  phase_e           ph_q, ph_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [DW-1:0]    wdat_q, wdat_d;
  logic [LANES-1:0] lane_q, lane_d;
  logic             ce_q, ce_d, we_q, we_d, oe_q, oe_d, drv_q, drv_d;
  logic             last_rd_q, last_rd_d;
  logic             cnt_load, cnt_done, cap_en;
  logic [CW-1:0]    cnt_val;

  always_comb begin
    ph_d      = ph_q;
    addr_d    = addr_q;
    wdat_d    = wdat_q;
    lane_d    = lane_q;
    ce_d      = ce_q;
    we_d      = we_q;
    oe_d      = oe_q;
    drv_d     = drv_q;
    last_rd_d = last_rd_q;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cap_en    = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (req_valid) begin
        addr_d = req_addr;
        wdat_d = req_wdata;
        lane_d = ~req_be;
        if (!req_write) begin
          ph_d      = PH_READ;
          ce_d      = 1'b0;
          oe_d      = 1'b0;
          last_rd_d = 1'b1;
          cnt_load  = 1'b1;
          cnt_val   = CW'(RD_CYC - 1);
        end else if (last_rd_q) begin
          ph_d      = PH_TURN;
          last_rd_d = 1'b0;
          cnt_load  = 1'b1;
          cnt_val   = CW'(TA_CYC - 1);
        end else begin
          ph_d = PH_WSET;
          ce_d = 1'b0;
        end
      end
      PH_READ: if (cnt_done) begin
        cap_en = 1'b1;
        ce_d   = 1'b1;
        oe_d   = 1'b1;
        lane_d = '1;
        ph_d   = PH_IDLE;
      end
      PH_TURN: if (cnt_done) begin
        ph_d = PH_WSET;
        ce_d = 1'b0;
      end
      PH_WSET: begin
        we_d     = 1'b0;
        ph_d     = PH_WPULSE;
        cnt_load = 1'b1;
        cnt_val  = CW'(WP_CYC - 1);
      end
      PH_WPULSE: begin
        drv_d = 1'b1;
        if (cnt_done) begin
          we_d = 1'b1;
          ph_d = PH_WREC;
        end
      end
      PH_WREC: begin
        drv_d  = 1'b0;
        ce_d   = 1'b1;
        lane_d = '1;
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ph_q      <= PH_IDLE;
      addr_q    <= '0;
      wdat_q    <= '0;
      lane_q    <= '1;
      ce_q      <= 1'b1;
      we_q      <= 1'b1;
      oe_q      <= 1'b1;
      drv_q     <= 1'b0;
      last_rd_q <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      addr_q    <= addr_d;
      wdat_q    <= wdat_d;
      lane_q    <= lane_d;
      ce_q      <= ce_d;
      we_q      <= we_d;
      oe_q      <= oe_d;
      drv_q     <= drv_d;
      last_rd_q <= last_rd_d;
    end
  end

  asram_phase_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_i), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  asram_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_i), .cap_en(cap_en), .lane_sel(~lane_q),
    .dq_in(mem_dq_in), .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );

  assign req_ready  = (ph_q == PH_IDLE);
  assign mem_addr   = addr_q;
  assign mem_ce_n   = ce_q;
  assign mem_we_n   = we_q;
  assign mem_oe_n   = oe_q;
  assign mem_lane_n = lane_q;
  assign mem_dq_out = wdat_q;
  assign mem_dq_oe  = drv_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);
  assert_drv_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_drv_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_ce_n);

  assert_we_blocks_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !mem_we_n) |=> $stable(mem_addr));

  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
module sim_asram_ctrl;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out, mem_dq_in;

  int total, bad;

  asram_ctrl u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // RAM model: unselected lanes read back a filler byte
  logic [15:0] ram [0:1023];
  logic [15:0] wlat;
  logic        we_prev;
  assign mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lane_n[0])
                           ? ram[mem_addr[9:0]][7:0]  : 8'hEE;
  assign mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lane_n[1])
                           ? ram[mem_addr[9:0]][15:8] : 8'hEE;

  // Per-cycle monitors
  int ce_run, we_run, ovl_run, oe_gap, rec_run;
  int viol_contend, viol_addr;
  logic drv_prev, ce_prev, rd_seen;
  logic [17:0] addr_prev;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n)
        wlat <= mem_dq_oe ? mem_dq_out : 16'hDEAD;
      if (!we_prev && mem_we_n && !mem_ce_n) begin
        if (!mem_lane_n[0]) ram[mem_addr[9:0]][7:0]  <= wlat[7:0];
        if (!mem_lane_n[1]) ram[mem_addr[9:0]][15:8] <= wlat[15:8];
        chk(we_run >= 3, "R5 write strobe cycles", we_run, 3);
        chk(ovl_run >= 2, "R6 data before strobe rise", ovl_run, 2);
        chk(mem_dq_oe, "R6 drivers held after strobe rise", mem_dq_oe, 1);
      end
      if (mem_dq_oe && !mem_oe_n) viol_contend++;
      if (ce_prev == 1'b0 && !mem_ce_n && !we_prev && mem_addr != addr_prev) viol_addr++;
      if (!mem_ce_n && !mem_oe_n) ce_run++;
      else if (ce_run != 0) begin
        chk(ce_run >= 3, "R2 read select cycles", ce_run, 3);
        ce_run = 0;
      end
      we_run  = mem_we_n ? 0 : we_run + 1;
      ovl_run = (!mem_we_n && mem_dq_oe) ? ovl_run + 1 : (mem_we_n ? 0 : ovl_run);
      if (!mem_oe_n) begin oe_gap = 0; rd_seen = 1'b1; end
      else oe_gap++;
      if (mem_dq_oe && !drv_prev && rd_seen) begin
        chk(oe_gap >= 5, "R8 turnaround before drive", oe_gap - 1, 4);
        rd_seen = 1'b0;
      end
      we_prev   = mem_we_n;
      drv_prev  = mem_dq_oe;
      ce_prev   = mem_ce_n;
      addr_prev = mem_addr;
    end
  end

  // Vector: {write, be[1:0], addr[17:0], wdata[15:0], expect[15:0]}
  localparam int NV = 12;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 2'b11, 18'h00005, 16'hA1B2, 16'h0000},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA1B2},
    {1'b1, 2'b01, 18'h00005, 16'h3344, 16'h0000},
    {1'b0, 2'b11, 18'h00005, 16'h0000, 16'hA144},
    {1'b1, 2'b10, 18'h00005, 16'h77FF, 16'h0000},
    {1'b0, 2'b01, 18'h00005, 16'h0000, 16'h0044},
    {1'b0, 2'b10, 18'h00005, 16'h0000, 16'h7700},
    {1'b1, 2'b11, 18'h3FFFF, 16'h0F0F, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'h0F0F},
    {1'b0, 2'b00, 18'h3FFFF, 16'h0000, 16'h0000},
    {1'b1, 2'b00, 18'h3FFFF, 16'hFFFF, 16'h0000},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'h0F0F}
  };

  // Called at a negedge; returns at a negedge.
  task automatic do_req(input bit wr, input logic [1:0] be, input logic [17:0] a,
                        input logic [15:0] d, input logic [15:0] exp, input string tag);
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 ready low in cycle", req_ready, 0);
    chk(mem_addr == a, "R10 address driven", mem_addr, a);
    if (!wr) begin
      chk(mem_lane_n == ~be, "R3 lane enables", mem_lane_n, ~be);
      for (int k = 0; k < 20 && !rsp_valid; k++) @(negedge clk);
      chk(rsp_valid && rsp_rdata == exp, tag, rsp_rdata, exp);
    end else begin
      for (int k = 0; k < 20 && !req_ready; k++) @(negedge clk);
    end
  endtask

  initial begin
    total = 0; bad = 0;
    ce_run = 0; we_run = 0; ovl_run = 0; oe_gap = 0; rec_run = 0;
    viol_contend = 0; viol_addr = 0;
    drv_prev = 1'b0; ce_prev = 1'b1; rd_seen = 1'b0; we_prev = 1'b1;
    addr_prev = '0; wlat = '0;
    for (int i = 0; i < 1024; i++) ram[i] = 16'h0000;
    req_valid = 1'b0; req_write = 1'b0; req_be = '0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(mem_lane_n == 2'b11 && !mem_dq_oe, "R1 lanes high drivers off", {mem_lane_n, mem_dq_oe}, 6);
    chk(req_ready && !rsp_valid, "R1 ready and no response", {req_ready, rsp_valid}, 2);

    // Vector walk: R2 R3 R4 R10
    for (int i = 0; i < NV; i++)
      do_req(VEC[i][52], VEC[i][51:50], VEC[i][49:32], VEC[i][31:16], VEC[i][15:0],
             VEC[i][52] ? "R4 write" : "R3 R4 read data");

    // R8 write right after a read
    do_req(1'b0, 2'b11, 18'h00005, 16'h0, 16'h7744, "R2 read before turnaround");
    do_req(1'b1, 2'b11, 18'h00006, 16'h5A5A, 16'h0, "R8 write");
    do_req(1'b0, 2'b11, 18'h00006, 16'h0, 16'h5A5A, "R4 read after turnaround");
    // R2 response pulse lasts one cycle
    @(negedge clk);
    chk(!rsp_valid, "R2 single-cycle response", rsp_valid, 0);
    // R9 request held while busy is taken once only
    do_req(1'b1, 2'b01, 18'h00007, 16'h00C3, 16'h0, "R9 write");
    do_req(1'b0, 2'b11, 18'h00007, 16'h0, 16'h00C3, "R9 single write");

    repeat (3) @(negedge clk);
    chk(viol_contend == 0, "R6 no drive while output enabled", viol_contend, 0);
    chk(viol_addr == 0, "R7 address stable in write overlap", viol_addr, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule